// File: doc/BRIEF.md
# USB Host Root-Port Control and Status Register

This block is the single 32-bit control and status word for one USB host root port. The link logic feeds it raw port conditions: the attach level, the overcurrent level, a pulse when a port reset sequence has finished, a pulse when a remote wakeup is seen, and a pulse when a disconnect is seen. The block samples these into readable status fields. It keeps sticky change flags that software clears by writing 1, and it ORs those flags into one port-interrupt output.

Software reads and writes the word over a single-cycle bus: a write strobe, 32-bit write data, and read data taken combinationally from the stored state. The word also holds the resume control, which drives resume signaling on the port, and the suspend state. Software places the port in suspend. Hardware takes it out of suspend when a wakeup or a disconnect occurs.

Top module: `hport_ctrl_reg`

## Requirements
- R1: After reset, every field reads 0 and `port_irq`, `resume_drive` and `suspended` are 0.
- R2: Bit 0 reads the attach level sampled at the previous clock edge, and software writes do not change it. Bit 1 is set when the attach level goes from 0 to 1, and writing 1 to bit 1 clears it.
- R3: Bit 2 (port enable) is set only when `reset_done` pulses. Writing 1 to bit 2 while it is 0 does not set it. Writing 1 to bit 2 while it is 1 clears it.
- R4: A `disc_seen` pulse, or an overcurrent level of 1, clears bit 2. Either one overrides a `reset_done` pulse in the same cycle.
- R5: Bit 3 is set in every cycle in which bit 2 changes value, and writing 1 to bit 3 clears it.
- R6: Bit 4 reads the overcurrent level sampled at the previous edge, and writes do not change it. Bit 5 is set whenever bit 4 changes, and writing 1 to bit 5 clears it.
- R7: Bit 6 (resume) takes the written value on every write, and `resume_drive` equals bit 6. A `wake_seen` pulse sets bit 6 to 1, even when a write of 0 to bit 6 occurs in the same cycle.
- R8: Writing 1 to bit 7 sets suspend, and writing 0 to bit 7 leaves it unchanged. A `wake_seen` or `disc_seen` pulse clears bit 7, even when the device is detached and even when a set occurs in the same cycle. `suspended` equals bit 7.
- R9: `port_irq` is the OR of bits 1, 3 and 5. Bits 31 to 8 always read 0.
- R10: When a hardware set of bit 1, 3 or 5 and a software write-1 clear of that flag occur in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_attached | input | 1 | Attach level from the link logic |
| ovc_level | input | 1 | Overcurrent level |
| reset_done | input | 1 | Pulse: port reset sequence finished |
| wake_seen | input | 1 | Pulse: remote wakeup detected |
| disc_seen | input | 1 | Pulse: disconnect detected |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational) |
| port_irq | output | 1 | Port interrupt summary |
| resume_drive | output | 1 | Drive resume signaling on the port |
| suspended | output | 1 | Port is in suspend |

## Verification
Each flag is driven through four patterns:
- A lone hardware event, which shows that the set path works.
- A lone write-1, which shows that the clear path works.
- A write-1 to a flag or field that is already 0, or is read-only, which shows that a write has no unintended effect.
- A hardware event and a software write in the same cycle, which separates set-wins from clear-wins.

The enable field is also tried with a `reset_done` pulse that arrives together with a disconnect, and with a `reset_done` pulse that arrives during overcurrent. These cases show whether the kill conditions override the hardware set. The resume and suspend fields are tried with wakeup and disconnect pulses that coincide with opposing software writes, which shows which source has priority.

// File: rtl/hport_pkg.sv
package hport_pkg;

    localparam int FIELD_W   = 8;
    localparam int NUM_FLAGS = 3;

    // Field positions within the word; software decodes these.
    localparam int B_CONN = 0;
    localparam int B_CDET = 1;
    localparam int B_EN   = 2;
    localparam int B_ENCH = 3;
    localparam int B_OVC  = 4;
    localparam int B_OVCH = 5;
    localparam int B_RES  = 6;
    localparam int B_SUSP = 7;

    // Flag slots for the sticky-flag array.
    localparam int F_CDET = 0;
    localparam int F_ENCH = 1;
    localparam int F_OVCH = 2;

    // Bit order matches the field positions above (susp is the MSB).
    typedef struct packed {
        logic susp;
        logic res;
        logic ovch;
        logic ovc;
        logic ench;
        logic en;
        logic cdet;
        logic conn;
    } port_state_t;

    typedef struct packed {
        logic conn_lvl;
        logic ovc_lvl;
        logic conn_rise;
        logic ovc_flip;
        logic en_set;
        logic en_kill;
        logic wake;
        logic disc;
    } port_evt_t;

    typedef struct packed {
        logic we;
        logic clr_cdet;
        logic clr_en;
        logic clr_ench;
        logic clr_ovch;
        logic res_val;
        logic set_susp;
    } sw_req_t;

    function automatic sw_req_t decode_write(logic we, logic [FIELD_W-1:0] d);
        sw_req_t r;
        r.we       = we;
        r.clr_cdet = we & d[B_CDET];
        r.clr_en   = we & d[B_EN];
        r.clr_ench = we & d[B_ENCH];
        r.clr_ovch = we & d[B_OVCH];
        r.res_val  = d[B_RES];
        r.set_susp = we & d[B_SUSP];
        return r;
    endfunction

endpackage

// File: rtl/hport_evt.sv
module hport_evt
    import hport_pkg::*;
(
    input  logic        dev_attached,
    input  logic        ovc_level,
    input  logic        reset_done,
    input  logic        wake_seen,
    input  logic        disc_seen,
    input  port_state_t st,
    output port_evt_t   evt
);
    always_comb begin
        evt.conn_lvl  = dev_attached;
        evt.ovc_lvl   = ovc_level;
        evt.conn_rise = dev_attached & ~st.conn;
        evt.ovc_flip  = ovc_level ^ st.ovc;
        evt.en_kill   = ovc_level | disc_seen;
        evt.en_set    = reset_done & ~(ovc_level | disc_seen);
        evt.wake      = wake_seen;
        evt.disc      = disc_seen;
    end
endmodule

// File: rtl/hport_sticky.sv
module hport_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Set has priority over clear so no event is lost.
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr);
    end
endmodule

// File: rtl/hport_state.sv
module hport_state
    import hport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  port_evt_t   evt,
    input  sw_req_t     sw,
    output port_state_t st
);
    logic                 en_q, en_n;
    logic                 conn_q, ovc_q, res_q, susp_q;
    logic [NUM_FLAGS-1:0] fset, fclr, fq;

    always_comb begin
        if (evt.en_kill)     en_n = 1'b0;
        else if (evt.en_set) en_n = 1'b1;
        else if (sw.clr_en)  en_n = 1'b0;
        else                 en_n = en_q;
    end

    always_comb begin
        fset         = '0;
        fclr         = '0;
        fset[F_CDET] = evt.conn_rise;
        fset[F_ENCH] = en_n ^ en_q;
        fset[F_OVCH] = evt.ovc_flip;
        fclr[F_CDET] = sw.clr_cdet;
        fclr[F_ENCH] = sw.clr_ench;
        fclr[F_OVCH] = sw.clr_ovch;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        hport_sticky u_flag (
            .clk (clk),
            .rst (rst),
            .set (fset[i]),
            .clr (fclr[i]),
            .q   (fq[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            conn_q <= 1'b0;
            ovc_q  <= 1'b0;
            res_q  <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            en_q   <= en_n;
            conn_q <= evt.conn_lvl;
            ovc_q  <= evt.ovc_lvl;
            res_q  <= evt.wake | (sw.we ? sw.res_val : res_q);
            susp_q <= (evt.wake | evt.disc) ? 1'b0 : (susp_q | sw.set_susp);
        end
    end

    always_comb begin
        st.conn = conn_q;
        st.cdet = fq[F_CDET];
        st.en   = en_q;
        st.ench = fq[F_ENCH];
        st.ovc  = ovc_q;
        st.ovch = fq[F_OVCH];
        st.res  = res_q;
        st.susp = susp_q;
    end
endmodule

// File: rtl/hport_ctrl_reg.sv
module hport_ctrl_reg
    import hport_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_attached,
    input  logic              ovc_level,
    input  logic              reset_done,
    input  logic              wake_seen,
    input  logic              disc_seen,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              port_irq,
    output logic              resume_drive,
    output logic              suspended
);
    localparam int PAD_W = DATA_W - FIELD_W;

    port_state_t st;
    port_evt_t   evt;
    sw_req_t     sw;
    logic        unused_wr_hi;

    assign sw           = decode_write(wr_en, wr_data[FIELD_W-1:0]);
    assign unused_wr_hi = ^wr_data[DATA_W-1:FIELD_W];

    hport_evt u_evt (
        .dev_attached (dev_attached),
        .ovc_level    (ovc_level),
        .reset_done   (reset_done),
        .wake_seen    (wake_seen),
        .disc_seen    (disc_seen),
        .st           (st),
        .evt          (evt)
    );

    hport_state u_state (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .sw  (sw),
        .st  (st)
    );

    assign rd_data      = {{PAD_W{1'b0}}, st};
    assign port_irq     = st.cdet | st.ench | st.ovch;
    assign resume_drive = st.res;
    assign suspended    = st.susp;
endmodule

// File: rtl/hport_chk.sv
module hport_chk (
    input logic        clk,
    input logic        rst,
    input logic        dev_attached,
    input logic        ovc_level,
    input logic        reset_done,
    input logic        wake_seen,
    input logic        disc_seen,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        port_irq,
    input logic        resume_drive,
    input logic        suspended
);
    // R3
    en_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[2]) |-> $past(reset_done));

    // R4
    en_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (ovc_level || disc_seen) |=> !rd_data[2]);

    // R5
    en_change_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[2] != $past(rd_data[2])) |-> rd_data[3]);

    // R7
    wake_resume_chk: assert property (@(posedge clk) disable iff (rst)
        wake_seen |=> resume_drive);

    // R8
    susp_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_seen || disc_seen) |=> !suspended);

    // R9
    irq_summary_chk: assert property (@(posedge clk) disable iff (rst)
        port_irq == (rd_data[1] | rd_data[3] | rd_data[5]));

    // R9
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:8] == 24'd0);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_attached && !rd_data[0] && wr_en && wr_data[1]) |=> rd_data[1]);

    // R2
    conn_track_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rd_data[0] == $past(dev_attached));
endmodule

bind hport_ctrl_reg hport_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dev_attached (dev_attached),
    .ovc_level    (ovc_level),
    .reset_done   (reset_done),
    .wake_seen    (wake_seen),
    .disc_seen    (disc_seen),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .port_irq     (port_irq),
    .resume_drive (resume_drive),
    .suspended    (suspended)
);

// File: tb/hport_ctrl_reg_test.sv
`timescale 1ns/1ps
module hport_ctrl_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_attached = 1'b0;
    logic        ovc_level = 1'b0;
    logic        reset_done = 1'b0;
    logic        wake_seen = 1'b0;
    logic        disc_seen = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        port_irq, resume_drive, suspended;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hport_ctrl_reg uut (
        .clk(clk), .rst(rst), .dev_attached(dev_attached), .ovc_level(ovc_level),
        .reset_done(reset_done), .wake_seen(wake_seen), .disc_seen(disc_seen),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .port_irq(port_irq),
        .resume_drive(resume_drive), .suspended(suspended)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Writes take effect at the next edge; sampling happens at the following negedge.
    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 outputs", {29'd0, port_irq, resume_drive, suspended}, 32'h0);
        rst = 1'b0;
        tick();
        chk("R1 after release", rd_data, 32'h0);
    endtask

    task automatic t_connect();
        dev_attached = 1'b1;
        tick();
        chk("R2 attach", rd_data, 32'h3);
        chk("R9 irq on connect", {31'd0, port_irq}, 32'h1);
        wr(32'h13);
        chk("R2 w1c, read-only bits kept", rd_data, 32'h1);
        chk("R9 irq cleared", {31'd0, port_irq}, 32'h0);
        dev_attached = 1'b0;
        tick();
        chk("R2 detach level", rd_data, 32'h0);
        dev_attached = 1'b1;
        wr(32'h2);
        chk("R10 set beats clear", rd_data, 32'h3);
        wr(32'h2);
        chk("R2 clear again", rd_data, 32'h1);
    endtask

    task automatic t_enable();
        wr(32'h4);
        chk("R3 write cannot set", rd_data, 32'h1);
        reset_done = 1'b1; tick(); reset_done = 1'b0;
        chk("R3 set by reset_done", rd_data, 32'hD);
        wr(32'h8);
        chk("R5 w1c change flag", rd_data, 32'h5);
        wr(32'h4);
        chk("R3 w1c disables", rd_data, 32'h9);
        wr(32'h8);
        reset_done = 1'b1; tick(); reset_done = 1'b0;
        wr(32'h8);
        chk("R3 re-enabled", rd_data, 32'h5);
        disc_seen = 1'b1; tick(); disc_seen = 1'b0;
        chk("R4 disconnect disables", rd_data, 32'h9);
        wr(32'h8);
        reset_done = 1'b1; disc_seen = 1'b1; tick();
        reset_done = 1'b0; disc_seen = 1'b0;
        chk("R4 disconnect beats reset_done", rd_data, 32'h1);
    endtask

    task automatic t_ovc();
        reset_done = 1'b1; tick(); reset_done = 1'b0;
        wr(32'h8);
        chk("R3 enabled before ovc", rd_data, 32'h5);
        ovc_level = 1'b1;
        tick();
        chk("R6 ovc rise", rd_data, 32'h39);
        reset_done = 1'b1; tick(); reset_done = 1'b0;
        chk("R4 ovc blocks enable", rd_data & 32'h4, 32'h0);
        wr(32'h20);
        chk("R6 w1c ovc flag", rd_data, 32'h19);
        ovc_level = 1'b0;
        tick();
        chk("R6 ovc fall sets flag", rd_data, 32'h29);
        wr(32'h28);
        chk("R6 cleared", rd_data, 32'h1);
        chk("R9 irq low", {31'd0, port_irq}, 32'h0);
    endtask

    task automatic t_resume();
        wr(32'h40);
        chk("R7 sw resume", {rd_data[6], resume_drive}, 32'h3);
        wr(32'h0);
        chk("R7 sw release", {rd_data[6], resume_drive}, 32'h0);
        wake_seen = 1'b1; tick(); wake_seen = 1'b0;
        chk("R7 wake sets resume", {rd_data[6], resume_drive}, 32'h3);
        wake_seen = 1'b1; wr(32'h0); wake_seen = 1'b0;
        chk("R7 wake beats write 0", {rd_data[6], resume_drive}, 32'h3);
        wr(32'h0);
        chk("R7 cleared", rd_data, 32'h1);
    endtask

    task automatic t_suspend();
        dev_attached = 1'b0;
        tick();
        wr(32'h80);
        chk("R8 sw sets suspend", {rd_data[7], suspended}, 32'h3);
        wr(32'h0);
        chk("R8 write 0 keeps suspend", {rd_data[7], suspended}, 32'h3);
        disc_seen = 1'b1; tick(); disc_seen = 1'b0;
        chk("R8 disconnect exits while detached", {rd_data[7], suspended}, 32'h0);
        wr(32'h80);
        wake_seen = 1'b1; tick(); wake_seen = 1'b0;
        chk("R8 wake exits suspend", {rd_data[7], suspended}, 32'h0);
        chk("R7 wake during suspend", {31'd0, resume_drive}, 32'h1);
        wr(32'h0);
        disc_seen = 1'b1; wr(32'h80); disc_seen = 1'b0;
        chk("R8 exit beats set", {rd_data[7], suspended}, 32'h0);
    endtask

    task automatic t_misc();
        wr(32'hFFFF_FF80);
        chk("R9 upper bits zero", rd_data, 32'h80);
        wake_seen = 1'b1; tick(); wake_seen = 1'b0;
        wr(32'h0);
        chk("R9 final state", rd_data, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        t_connect();
        t_enable();
        t_ovc();
        t_resume();
        t_suspend();
        t_misc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule